// File: doc/BRIEF.md
# PWM Channel with Latched Full-Duty Override

This block is one pulse-width-modulation channel together with the free-running counter that paces it. The counter counts from zero up to a programmable period value, then returns to zero. In the cycle where it wraps, it raises a one-clock overflow strobe. The channel keeps an internal phase bit that marks the active part of the period. An overflow can set this bit to active. A match between the counter and a compare value applies one of four programmable actions to it. A polarity input chooses which pin level counts as active.

A full-duty override input can hold the pin at the active level for whole periods. It acts only when the channel is set to go active on overflow and to clear on compare. The block copies the override input into an internal flag only at period boundaries. A change of the input therefore never cuts into the period that is already running. It applies from the next period, both when the override is set and when it is released.

Top module: `pwm_duty_chan`

## Requirements
- R1: `cnt_o` is 0 after reset and rises by one per clock until it reaches `period_i`. In the cycle where `cnt_o` is at or above `period_i`, `ovf_o` is high for that one cycle, and `cnt_o` is 0 in the next cycle.
- R2: With `tov_en_i`=1 and clear mode (`cmp_mode_i`=2'b10), the pin is at the active level while `cnt_o` runs from 0 through `cmp_i`. It is at the inactive level for the rest of the period, so there are `cmp_i`+1 active cycles per period.
- R3: A `cmp_i` equal to or above `period_i` causes no transition inside the period. With `tov_en_i`=1 in clear mode, this gives a steady active level.
- R4: When the latched override flag is set, `tov_en_i`=1 and `cmp_mode_i`=2'b10, the pin stays at the active level for the whole period. With any other mode, or with `tov_en_i`=0, the override has no effect on the pin.
- R5: `max_duty_i` is sampled only at the clock edge that ends the `ovf_o` cycle. A set or a clear made in the middle of a period leaves that period unchanged and takes effect from the next `cnt_o`=0. A value present during the `ovf_o` cycle applies to the period that follows at once.
- R6: The active level equals `pol_i`. With `pol_i`=1, full duty is a steady high and zero duty a steady low. With `pol_i`=0, full duty is a steady low and zero duty a steady high.
- R7: On a compare match (`cnt_o`==`cmp_i`, not in the `ovf_o` cycle), the mode acts on the phase bit from the next cycle: 2'b00 leaves it alone, 2'b01 inverts it, 2'b10 clears it, 2'b11 sets it.
- R8: While `rst_n` is low, the counter and the override flag are cleared and the pin sits at the inactive level.
- R9: With `tov_en_i`=0, an overflow never makes the phase active. In clear mode the pin then stays at zero duty, with or without the override.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| period_i | input | CNT_W | Last count value before wrap |
| cmp_i | input | CNT_W | Compare value |
| cmp_mode_i | input | 2 | Compare action: 00 none, 01 toggle, 10 clear, 11 set |
| tov_en_i | input | 1 | Go active on overflow |
| max_duty_i | input | 1 | Full-duty override request |
| pol_i | input | 1 | Active pin level |
| cnt_o | output | CNT_W | Counter value |
| ovf_o | output | 1 | One-cycle wrap strobe |
| pwm_o | output | 1 | PWM pin level |

## Verification
The override flag is updated at the same edge where the counter wraps and the phase bit is set active. The interesting collision is a change of `max_duty_i` that arrives in the overflow cycle itself, compared with one that arrives in the middle of a period. The bench changes the override input on the falling edge of the `ovf_o` cycle and also on the falling edge of a mid-period cycle. It then checks the pin after the compare point, both in the current period and in the next one. A capture at the boundary must govern the next period at once, while a mid-period change must wait one full period.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
   typedef enum logic [1:0] {
      CMP_NONE   = 2'b00,
      CMP_TOGGLE = 2'b01,
      CMP_CLEAR  = 2'b10,
      CMP_SET    = 2'b11
   } cmp_act_e;
endpackage

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr #(
   parameter int CNT_W   = 16,
   parameter bit WRAP_GE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("pwm_period_ctr: CNT_W out of range");
      end
      if (WRAP_GE) begin : g_wrap_ge
         assign wrap = (cnt >= period);
      end else begin : g_wrap_eq
         assign wrap = (cnt == period);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (wrap) cnt <= '0;
      else           cnt <= cnt + ONE;
   end
endmodule

// File: rtl/pwm_max_latch.sv
module pwm_max_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic wrap,
   input  logic req,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    flag <= 1'b0;
      else if (wrap) flag <= req;
   end
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage
   import pwm_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] cmp,
   input  logic             wrap,
   input  logic [1:0]       mode,
   input  logic             tov_en,
   input  logic             ovr_flag,
   input  logic             pol,
   output logic             phase,
   output logic             pin
);
   cmp_act_e act;
   logic     match;
   logic     force_full;
   logic     eff;

   assign act        = cmp_act_e'(mode);
   assign match      = (cnt == cmp) && !wrap;
   assign force_full = ovr_flag && tov_en && (act == CMP_CLEAR);
   assign eff        = force_full | phase;
   assign pin        = eff ? pol : ~pol;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= 1'b0;
      end else if (wrap) begin
         if (tov_en) phase <= 1'b1;
      end else if (match) begin
         unique case (act)
            CMP_NONE:   phase <= phase;
            CMP_TOGGLE: phase <= ~phase;
            CMP_CLEAR:  phase <= 1'b0;
            CMP_SET:    phase <= 1'b1;
         endcase
      end
   end
endmodule

// File: rtl/pwm_duty_chan.sv
module pwm_duty_chan #(
   parameter int CNT_W   = 16,
   parameter bit WRAP_GE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] period_i,
   input  logic [CNT_W-1:0] cmp_i,
   input  logic [1:0]       cmp_mode_i,
   input  logic             tov_en_i,
   input  logic             max_duty_i,
   input  logic             pol_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             ovf_o,
   output logic             pwm_o
);
   logic wrap_w;
   logic ovr_w;
   logic phase_w;

   pwm_period_ctr #(.CNT_W(CNT_W), .WRAP_GE(WRAP_GE)) u_ctr (
      .clk(clk), .rst_n(rst_n), .period(period_i), .cnt(cnt_o), .wrap(wrap_w)
   );

   pwm_max_latch u_latch (
      .clk(clk), .rst_n(rst_n), .wrap(wrap_w), .req(max_duty_i), .flag(ovr_w)
   );

   pwm_out_stage #(.CNT_W(CNT_W)) u_out (
      .clk(clk), .rst_n(rst_n), .cnt(cnt_o), .cmp(cmp_i), .wrap(wrap_w),
      .mode(cmp_mode_i), .tov_en(tov_en_i), .ovr_flag(ovr_w), .pol(pol_i),
      .phase(phase_w), .pin(pwm_o)
   );

   assign ovf_o = wrap_w;
endmodule

// File: rtl/pwm_duty_chan_chk.sv
module pwm_duty_chan_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] cnt_o,
   input logic [CNT_W-1:0] cmp_i,
   input logic [1:0]       cmp_mode_i,
   input logic             tov_en_i,
   input logic             max_duty_i,
   input logic             pol_i,
   input logic             ovf_o,
   input logic             pwm_o,
   input logic             ovr_w,
   input logic             phase_w
);
   AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |=> (cnt_o == '0)); // R1
   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !ovf_o |=> (cnt_o == $past(cnt_o) + 1'b1)); // R1
   AST_FULL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_w && tov_en_i && cmp_mode_i == 2'b10) |-> (pwm_o == pol_i)); // R4
   AST_FLAG_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      !ovf_o |=> (ovr_w == $past(ovr_w))); // R5
   AST_FLAG_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |=> (ovr_w == $past(max_duty_i))); // R5
   AST_OVF_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_o && tov_en_i) |=> phase_w); // R2
   AST_CLEAR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_mode_i == 2'b10 && cnt_o == cmp_i && !ovf_o) |=> !phase_w); // R7
   AST_PIN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovr_w && !phase_w) |-> (pwm_o == !pol_i)); // R6
endmodule

bind pwm_duty_chan pwm_duty_chan_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cnt_o(cnt_o), .cmp_i(cmp_i),
   .cmp_mode_i(cmp_mode_i), .tov_en_i(tov_en_i), .max_duty_i(max_duty_i),
   .pol_i(pol_i), .ovf_o(ovf_o), .pwm_o(pwm_o), .ovr_w(ovr_w),
   .phase_w(phase_w)
);

// File: tb/pwm_duty_chan_tb_top.sv
module pwm_duty_chan_tb_top;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] period_i = 16'd9;
   logic [W-1:0] cmp_i = 16'd4;
   logic [1:0]   cmp_mode_i = 2'b10;
   logic         tov_en_i = 1'b1;
   logic         max_duty_i = 1'b0;
   logic         pol_i = 1'b1;
   logic [W-1:0] cnt_o;
   logic         ovf_o;
   logic         pwm_o;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   pwm_duty_chan #(.CNT_W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .period_i(period_i), .cmp_i(cmp_i),
      .cmp_mode_i(cmp_mode_i), .tov_en_i(tov_en_i), .max_duty_i(max_duty_i),
      .pol_i(pol_i), .cnt_o(cnt_o), .ovf_o(ovf_o), .pwm_o(pwm_o)
   );

   typedef struct packed {
      logic [15:0] per;
      logic [15:0] cmp;
      logic [1:0]  mode;
      logic        tov;
      logic        pol;
      logic        maxd;
      logic [16:0] exp_act;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{16'd9,  16'd4,  2'b10, 1'b1, 1'b1, 1'b0, 17'd5},   // R2
      '{16'd9,  16'd0,  2'b10, 1'b1, 1'b1, 1'b0, 17'd1},   // R2
      '{16'd9,  16'd9,  2'b10, 1'b1, 1'b1, 1'b0, 17'd10},  // R3
      '{16'd9,  16'd12, 2'b10, 1'b1, 1'b1, 1'b0, 17'd10},  // R3
      '{16'd9,  16'd4,  2'b10, 1'b1, 1'b1, 1'b1, 17'd10},  // R4
      '{16'd9,  16'd4,  2'b01, 1'b1, 1'b1, 1'b1, 17'd5},   // R4 R7
      '{16'd9,  16'd4,  2'b11, 1'b1, 1'b1, 1'b0, 17'd10},  // R7
      '{16'd9,  16'd4,  2'b00, 1'b1, 1'b1, 1'b0, 17'd10},  // R7
      '{16'd9,  16'd4,  2'b10, 1'b0, 1'b1, 1'b1, 17'd0},   // R9
      '{16'd5,  16'd2,  2'b10, 1'b1, 1'b0, 1'b0, 17'd3},   // R6
      '{16'd5,  16'd2,  2'b10, 1'b1, 1'b0, 1'b1, 17'd6},   // R6
      '{16'd15, 16'd7,  2'b01, 1'b1, 1'b1, 1'b0, 17'd8}    // R7
   };

   function automatic string vec_req(int i);
      case (i)
         0, 1:    return "R2";
         2, 3:    return "R3";
         4, 5:    return "R4";
         8:       return "R9";
         9, 10:   return "R6";
         default: return "R7";
      endcase
   endfunction

   task automatic check(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic wait_cnt(int v);
      do @(negedge clk); while (cnt_o != v[W-1:0]);
   endtask

   task automatic wait_ovf();
      do @(negedge clk); while (!ovf_o);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      // R8: reset state
      repeat (3) @(negedge clk);
      check("R8", "cnt in reset", int'(cnt_o), 0);
      check("R8", "pin in reset", int'(pwm_o), 0);
      check("R8", "ovf in reset", int'(ovf_o), 0);
      rst_n = 1'b1;

      // R1: count up and wrap
      wait_ovf();
      check("R1", "cnt at wrap", int'(cnt_o), 9);
      @(negedge clk);
      check("R1", "cnt after wrap", int'(cnt_o), 0);
      check("R1", "ovf after wrap", int'(ovf_o), 0);

      // table walk
      for (int i = 0; i < NV; i++) begin
         int hits;
         period_i   = VECS[i].per;
         cmp_i      = VECS[i].cmp;
         cmp_mode_i = VECS[i].mode;
         tov_en_i   = VECS[i].tov;
         pol_i      = VECS[i].pol;
         max_duty_i = VECS[i].maxd;
         wait_ovf();
         wait_ovf();
         hits = 0;
         for (int k = 0; k <= int'(VECS[i].per); k++) begin
            @(negedge clk);
            if (pwm_o == VECS[i].pol) hits++;
         end
         check(vec_req(i), $sformatf("active cycles vec %0d", i),
               hits, int'(VECS[i].exp_act));
      end

      // R5: mid-period set and clear wait a full period
      period_i = 16'd9; cmp_i = 16'd4; cmp_mode_i = 2'b10;
      tov_en_i = 1'b1; pol_i = 1'b1; max_duty_i = 1'b0;
      wait_ovf(); wait_ovf();
      wait_cnt(2); max_duty_i = 1'b1;
      wait_cnt(6);
      check("R5", "set mid-period, same period", int'(pwm_o), 0);
      wait_cnt(6);
      check("R5", "set mid-period, next period", int'(pwm_o), 1);
      wait_cnt(2); max_duty_i = 1'b0;
      wait_cnt(6);
      check("R5", "clear mid-period, same period", int'(pwm_o), 1);
      wait_cnt(6);
      check("R5", "clear mid-period, next period", int'(pwm_o), 0);

      // R5: change in the overflow cycle applies at once
      wait_ovf(); max_duty_i = 1'b1;
      wait_cnt(6);
      check("R5", "set in ovf cycle", int'(pwm_o), 1);
      wait_ovf(); max_duty_i = 1'b0;
      wait_cnt(6);
      check("R5", "clear in ovf cycle", int'(pwm_o), 0);

      // R6: polarity 0 zero duty is a steady high
      tov_en_i = 1'b0; pol_i = 1'b0;
      wait_ovf(); wait_ovf();
      wait_cnt(1);
      check("R6", "zero duty pol0 early", int'(pwm_o), 1);
      wait_cnt(8);
      check("R6", "zero duty pol0 late", int'(pwm_o), 1);

      // R8: reset during forced full duty
      tov_en_i = 1'b1; pol_i = 1'b1; max_duty_i = 1'b1;
      wait_ovf(); wait_cnt(6);
      check("R4", "forced before reset", int'(pwm_o), 1);
      rst_n = 1'b0;
      @(negedge clk);
      check("R8", "pin after mid-run reset", int'(pwm_o), 0);
      check("R8", "cnt after mid-run reset", int'(cnt_o), 0);
      max_duty_i = 1'b0;
      rst_n = 1'b1;
      wait_cnt(6);
      check("R8", "override cleared by reset", int'(pwm_o), 0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule